// File: doc/BRIEF.md
# Clock and Battery-RAM Host Bridge

This block sits between a host processor bus and a byte-oriented real-time-clock and battery-RAM engine. It gives the host two byte-wide registers. A data byte is selected by `host_addr = 0`, and a control byte by `host_addr = 1`. When the host writes the control byte with its top bit set, the bridge launches one byte transaction toward the engine. The transaction either sends the data byte out or brings a byte back into it. The top control bit stays set while the transaction is in flight. Software polls that bit to learn when the transaction has finished.

The engine side uses two channels, each with a valid/ready handshake:

- **Request channel.** It carries the direction and the outgoing byte. Once `eng_req_valid` is raised, the payload holds steady until the engine accepts it by raising `eng_req_ready`. Only one request is offered per transaction.
- **Response channel.** It returns one completion beat per transaction, with the received byte. The bridge raises `eng_rsp_ready` only after its request has been accepted. An engine that asserts `eng_rsp_valid` at any other time is held off and has no effect.

Alongside the two channels, a level output marks the active command frame, and a one-cycle pulse tells the engine that the frame has been closed.

The four lowest control bits hold unrelated display state. The bridge stores them and returns them unchanged on reads.

Top module: `rtcb_bridge`

## Requirements
- R1: After reset, both registers read 0x00, `eng_req_valid` is 0 and `eng_eof` is 0.
- R2: A host write with `host_addr=0` sets the data register, and one with `host_addr=1` sets the control register. Reads return the stored byte through `host_rdata`, which follows `host_addr` combinationally. Control bit 4 always reads 0, whatever is written.
- R3: Control bits 3..0 read back as last written. They are updated by control writes even while a transaction is busy, and completion leaves them untouched.
- R4: A control write with bit 7 set, made while idle, raises `eng_req_valid` in the following cycle. The request carries `eng_req_dir` from bit 6 (0 means send, 1 means receive) and `eng_req_byte` equal to the data register. `eng_frame` follows control bit 5.
- R5: While `eng_req_valid` is high and `eng_req_ready` is low, the request and its payload stay stable. Each transaction offers exactly one request.
- R6: Control bit 7 reads 1 from the cycle after the launching write until the response handshake. It reads 0 from the cycle after that handshake.
- R7: For a receive, the response byte is stored in the data register at the response handshake. For a send, the data register keeps its value.
- R8: While bit 7 is set, host writes to the data register are ignored, and control writes leave bits 7..4 unchanged. In particular, writing bit 7 again does not start a second transaction.
- R9: A control write that changes bit 5 from 1 to 0 produces a single-cycle `eng_eof` pulse in the following cycle. A write that leaves bit 5 at 0 produces none.
- R10: `eng_rsp_ready` is high only after the request has been accepted and before its response. A response offered while idle is not accepted and does not change the data register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 1 | Host access strobe |
| host_wr | input | 1 | Host write (1) or read (0) |
| host_addr | input | 1 | 0 selects the data register, 1 selects the control register |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Selected register contents |
| eng_req_valid | output | 1 | Request offered to the engine |
| eng_req_ready | input | 1 | Engine accepts the request |
| eng_req_dir | output | 1 | 0 sends the byte, 1 asks for a byte |
| eng_req_byte | output | 8 | Byte sent to the engine |
| eng_frame | output | 1 | Command frame active (control bit 5) |
| eng_eof | output | 1 | One-cycle pulse when the frame closes |
| eng_rsp_valid | input | 1 | Engine completion beat |
| eng_rsp_ready | output | 1 | Bridge accepts the completion |
| eng_rsp_byte | input | 8 | Byte returned by the engine |

## Verification
Two functions can fall in the same cycle: the engine completing a transaction, and the host rewriting the control byte. The bench provokes this by having the engine model fire an event in the very cycle it raises its response. The host then writes the control register during that same cycle. Afterwards, the bench requires the following:

- bit 7 has cleared;
- bits 6..5 have kept their launch values;
- the new display nibble has been stored;
- the received byte has landed in the data register.

// File: rtl/rtcb_pkg.sv
package rtcb_pkg;
  localparam int BYTE_W   = 8;
  localparam int BORDER_W = 4;

  typedef struct packed {
    logic                start;
    logic                dir;
    logic                frame;
    logic                rsv;
    logic [BORDER_W-1:0] border;
  } ctrl_t;
endpackage

// File: rtl/rtcb_regs.sv
module rtcb_regs
  import rtcb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_data_en,
  input  logic              wr_ctrl_en,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              done,
  input  logic              rx_load,
  input  logic [BYTE_W-1:0] rx_byte,
  output ctrl_t             ctrl_q,
  output logic [BYTE_W-1:0] data_q
);
  ctrl_t ctrl_wr;

  always_comb begin
    ctrl_wr     = ctrl_t'(wdata);
    ctrl_wr.rsv = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else begin
      if (wr_ctrl_en) begin
        if (ctrl_q.start) ctrl_q.border <= ctrl_wr.border;
        else              ctrl_q        <= ctrl_wr;
      end
      if (done) ctrl_q.start <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                           data_q <= '0;
    else if (rx_load)                     data_q <= rx_byte;
    else if (wr_data_en && !ctrl_q.start) data_q <= wdata;
  end
endmodule

// File: rtl/rtcb_seq.sv
module rtcb_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic busy,
  input  logic req_ready,
  input  logic rsp_valid,
  output logic req_valid,
  output logic rsp_ready,
  output logic done
);
  logic issued_q;

  assign req_valid = busy && !issued_q;
  assign rsp_ready = issued_q;
  assign done      = issued_q && rsp_valid;

  always_ff @(posedge clk) begin
    if (!rst_n)                     issued_q <= 1'b0;
    else if (done)                  issued_q <= 1'b0;
    else if (req_valid && req_ready) issued_q <= 1'b1;
  end
endmodule

// File: rtl/rtcb_eof.sv
module rtcb_eof (
  input  logic clk,
  input  logic rst_n,
  input  logic frame,
  output logic eof
);
  logic frame_d;

  always_ff @(posedge clk) begin
    if (!rst_n) frame_d <= 1'b0;
    else        frame_d <= frame;
  end

  assign eof = frame_d && !frame;
endmodule

// File: rtl/rtcb_bridge.sv
module rtcb_bridge
  import rtcb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_sel,
  input  logic              host_wr,
  input  logic              host_addr,
  input  logic [BYTE_W-1:0] host_wdata,
  output logic [BYTE_W-1:0] host_rdata,
  output logic              eng_req_valid,
  input  logic              eng_req_ready,
  output logic              eng_req_dir,
  output logic [BYTE_W-1:0] eng_req_byte,
  output logic              eng_frame,
  output logic              eng_eof,
  input  logic              eng_rsp_valid,
  output logic              eng_rsp_ready,
  input  logic [BYTE_W-1:0] eng_rsp_byte
);
  ctrl_t             ctrl_q;
  logic [BYTE_W-1:0] data_q;
  logic              wr_data_en, wr_ctrl_en, done;

  assign wr_data_en = host_sel && host_wr && !host_addr;
  assign wr_ctrl_en = host_sel && host_wr &&  host_addr;

  rtcb_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_data_en (wr_data_en),
    .wr_ctrl_en (wr_ctrl_en),
    .wdata      (host_wdata),
    .done       (done),
    .rx_load    (done && ctrl_q.dir),
    .rx_byte    (eng_rsp_byte),
    .ctrl_q     (ctrl_q),
    .data_q     (data_q)
  );

  rtcb_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (ctrl_q.start),
    .req_ready (eng_req_ready),
    .rsp_valid (eng_rsp_valid),
    .req_valid (eng_req_valid),
    .rsp_ready (eng_rsp_ready),
    .done      (done)
  );

  rtcb_eof u_eof (
    .clk   (clk),
    .rst_n (rst_n),
    .frame (ctrl_q.frame),
    .eof   (eng_eof)
  );

  assign eng_req_dir  = ctrl_q.dir;
  assign eng_req_byte = data_q;
  assign eng_frame    = ctrl_q.frame;
  assign host_rdata   = host_addr ? BYTE_W'(ctrl_q) : data_q;
endmodule

// File: rtl/rtcb_bridge_chk.sv
module rtcb_bridge_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] ctrl_bits,
  input logic [7:0] data_q,
  input logic       req_valid,
  input logic       req_ready,
  input logic       req_dir,
  input logic [7:0] req_byte,
  input logic       frame,
  input logic       eof,
  input logic       rsp_valid,
  input logic       rsp_ready
);
  a_r5_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_dir) && $stable(req_byte) && $stable(frame));

  a_r5_single_req: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_valid);

  a_r10_rsp_gate: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ready |-> ctrl_bits[7] && !req_valid);

  a_r8_data_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_bits[7] && !(rsp_valid && rsp_ready) |=> $stable(data_q));

  a_r6_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_ready |=> !ctrl_bits[7]);

  a_r9_eof_edge: assert property (@(posedge clk) disable iff (!rst_n)
    eof |-> !frame && $past(frame));

  a_r2_rsv_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_bits[4]);
endmodule

bind rtcb_bridge rtcb_bridge_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ctrl_bits (ctrl_q),
  .data_q    (data_q),
  .req_valid (eng_req_valid),
  .req_ready (eng_req_ready),
  .req_dir   (eng_req_dir),
  .req_byte  (eng_req_byte),
  .frame     (eng_frame),
  .eof       (eng_eof),
  .rsp_valid (eng_rsp_valid),
  .rsp_ready (eng_rsp_ready)
);

// File: tb/rtcb_bridge_test.sv
module rtcb_bridge_test;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       host_sel = 0, host_wr = 0, host_addr = 0;
  logic [7:0] host_wdata = 0;
  logic [7:0] host_rdata;
  logic       eng_req_valid, eng_req_ready = 0, eng_req_dir;
  logic [7:0] eng_req_byte;
  logic       eng_frame, eng_eof;
  logic       eng_rsp_valid = 0, eng_rsp_ready;
  logic [7:0] eng_rsp_byte = 0;

  int checks = 0, errors = 0;
  bit finished = 0;
  int stall = 0, gap = 1;
  logic [7:0] rx_next = 0;
  logic [9:0] exp_q[$];
  event rsp_go;

  always #5 clk = ~clk;

  rtcb_bridge uut (.*);

  task automatic check(input string req, input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic a, input logic [7:0] d);
    @(negedge clk);
    host_sel = 1; host_wr = 1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_sel = 0; host_wr = 0;
  endtask

  task automatic host_read(input logic a, output logic [7:0] d);
    host_addr = a;
    #1 d = host_rdata;
  endtask

  task automatic wait_idle();
    logic [7:0] v;
    for (int i = 0; i < 60; i++) begin
      host_read(1, v);
      if (!v[7]) break;
      @(negedge clk);
    end
  endtask

  // engine model
  initial begin
    forever begin
      @(negedge clk);
      if (eng_req_valid) begin
        repeat (stall) @(negedge clk);
        eng_req_ready = 1;
        @(negedge clk);
        eng_req_ready = 0;
        repeat (gap) @(negedge clk);
        eng_rsp_valid = 1; eng_rsp_byte = rx_next;
        -> rsp_go;
        @(negedge clk);
        eng_rsp_valid = 0;
      end
    end
  end

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk); #1;
      if (eng_req_valid && eng_req_ready) begin
        if (exp_q.size() == 0) check("R5 unexpected request", {eng_req_dir, eng_frame, eng_req_byte}, 10'h3ff);
        else check("R4 request payload", {eng_req_dir, eng_frame, eng_req_byte}, exp_q.pop_front());
      end
    end
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    host_read(0, v); check("R1 data reset", {2'b0, v}, 10'h000);
    host_read(1, v); check("R1 ctrl reset", {2'b0, v}, 10'h000);
    check("R1 outputs", {8'b0, eng_req_valid, eng_eof}, 10'h0);
    // R2 R3
    host_write(0, 8'h5A); host_read(0, v); check("R2 data readback", {2'b0, v}, 10'h05A);
    host_write(1, 8'h1F); host_read(1, v); check("R2 R3 ctrl readback bit4 zero", {2'b0, v}, 10'h00F);
    // R4 R6 R8 R7 send with stall
    stall = 3; gap = 2;
    host_write(0, 8'hC3);
    exp_q.push_back({1'b0, 1'b1, 8'hC3});
    host_write(1, 8'hA5);
    host_read(1, v); check("R6 busy after launch", {9'b0, v[7]}, 10'h001);
    check("R4 request valid", {9'b0, eng_req_valid}, 10'h001);
    host_write(0, 8'h11);
    host_write(1, 8'hDA);
    host_read(1, v); check("R8 R3 busy ctrl write", {2'b0, v}, 10'h0AA);
    wait_idle();
    host_read(1, v); check("R6 cleared after done", {2'b0, v}, 10'h02A);
    host_read(0, v); check("R7 R8 send keeps data", {2'b0, v}, 10'h0C3);
    // R7 receive
    stall = 0; gap = 1; rx_next = 8'h96;
    exp_q.push_back({1'b1, 1'b1, 8'hC3});
    host_write(1, 8'hE2);
    wait_idle();
    host_read(0, v); check("R7 received byte", {2'b0, v}, 10'h096);
    host_read(1, v); check("R6 receive done ctrl", {2'b0, v}, 10'h062);
    // collision: control write in completion cycle
    gap = 2; rx_next = 8'h3C;
    exp_q.push_back({1'b1, 1'b1, 8'h96});
    host_write(1, 8'hE2);
    @(rsp_go);
    host_sel = 1; host_wr = 1; host_addr = 1; host_wdata = 8'h07;
    @(negedge clk);
    host_sel = 0; host_wr = 0;
    host_read(1, v); check("R3 R6 collision ctrl", {2'b0, v}, 10'h067);
    host_read(0, v); check("R7 collision data", {2'b0, v}, 10'h03C);
    // R9
    host_write(1, 8'h07);
    #1 check("R9 eof pulse", {9'b0, eng_eof}, 10'h001);
    @(negedge clk); #1 check("R9 eof single cycle", {9'b0, eng_eof}, 10'h000);
    host_write(1, 8'h03);
    #1 check("R9 no eof when frame stays low", {9'b0, eng_eof}, 10'h000);
    // R10 spurious response
    @(negedge clk);
    eng_rsp_valid = 1; eng_rsp_byte = 8'hFF;
    #1 check("R10 no ready while idle", {9'b0, eng_rsp_ready}, 10'h000);
    @(negedge clk); @(negedge clk);
    eng_rsp_valid = 0;
    host_read(0, v); check("R10 data untouched", {2'b0, v}, 10'h03C);
    // back-to-back with bits 6..5 held, then frame low
    rx_next = 8'h00; gap = 1;
    host_write(0, 8'h81);
    exp_q.push_back({1'b0, 1'b1, 8'h81});
    host_write(1, 8'hA0);
    wait_idle();
    host_write(0, 8'h42);
    exp_q.push_back({1'b0, 1'b1, 8'h42});
    host_write(1, 8'hA0);
    wait_idle();
    exp_q.push_back({1'b0, 1'b0, 8'h42});
    host_write(1, 8'h80);
    wait_idle();
    repeat (3) @(negedge clk);
    check("R5 all requests seen once", {2'b0, 8'(exp_q.size())}, 10'h000);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule